// File: doc/BRIEF.md
# Shadow Page Storage-Key Walker

This block is a sequential assist for a hypervisor. It carries out three key operations on behalf of a guest: reset reference bit, insert key and set key. It does so by walking the shadow tables the hypervisor keeps in main memory. Each command carries a control word, an operand address, a source byte and an opcode.

From the control word the walker finds a control block. From there it reaches a shadow segment table, a page table and a swap-flag table, all through a single word-addressed memory port. It then forms the guest view of the storage key by combining the swap-flag key byte with the reference and change bits of the real key array. When the page is resident, it reads the real key array and, where the operation calls for it, updates it. It writes the swap-flag word back.

Any condition the walker cannot handle makes it decline the command, and software then performs the operation. A declined command leaves memory and keys untouched.

Commands enter on a valid/ready channel that accepts one command at a time; `cmd_ready` is high only while the walker is idle. Results leave on a valid/ready channel. Once `rsp_valid` rises, the response is held unchanged until `rsp_ready` is seen high at a clock edge. A stalled consumer therefore blocks the next command and loses nothing. Memory accesses use a request/acknowledge handshake with any number of wait cycles. The real key array is read combinationally through an index and is written with a one-cycle strobe.

Top module: `skey_walker`

## Requirements
- R1: A command is declined at once, with no memory or key access, when bits 31:29 of `cmd_cr6` are not 3'b100, when the opcode is 3, or when the opcode is set key (2) and `cmd_src[3:0]` is nonzero. The opcodes are 0 reset reference, 1 insert key and 2 set key.
- R2: The control block starts at word index `{cmd_cr6[AW-1:3],1'b0}`. Its word 0 holds the segment table byte pointer in bits AW-1:0. If bit 1 of word 0 is set, the command is declined.
- R3: With bit 0 of word 0 set, segment = address[AW-1:19] and page = address[18:12]. Otherwise segment = address[AW-1:16] and page = address[15:12]. The segment entry is read at word (pointer>>2)+segment.
- R4: The command is declined when the top byte of the segment entry is less than or equal to address>>20.
- R5: The swap table base is read from the word just before the page table, at (entry[AW-1:0]>>2)-1. The swap-flag word is at byte base+8·page. The page word is at byte entry[AW-1:0]+2·page. An even page uses bits 31:16 of the page word and an odd page uses bits 15:0.
- R6: A page is resident when bits 3:1 of its halfword are zero. Its real key index is {halfword[15:4], address[11]}, the real byte address shifted right by 11.
- R7: The virtual key is swap-flag bits 7:0 when address bit 11 is set (odd half) and bits 15:8 otherwise, ANDed with 0xFE. When the page is resident, bits 2:1 of the real key are ORed into it.
- R8: Reset reference completes with cc = key[2:1] and `rsp_key` = key. On a resident page it writes the real key with bit 2 cleared. It writes back the swap flags ANDed with 0xFCFFFFFB for the odd half or 0xF3FFFBFF for the even half.
- R9: Set key declines on a non-resident page. Otherwise it writes real key {src[7:4], old[3:0]} and returns that value in `rsp_key`. It also rewrites the swap flags: old real key bits 2:1 go into bits 25:24 (odd half) or 27:26 (even half), and `cmd_src` goes into the matching key byte.
- R10: Insert key reads the control block word 2 as a pointer to the guest status word. It returns the key with bits 3:0 cleared when bit 19 of that word is 0 (basic mode). It writes nothing.
- R11: Every accepted command gives exactly one response, either done or declined. The response is held while `rsp_ready` is low. A memory request holds its address until acknowledged. `rsp_cc` is zero except on a completed reset reference, and `rsp_key` is zero on a decline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Walker idle, command accepted this cycle |
| cmd_op | input | 2 | Opcode: 0 reset reference, 1 insert, 2 set |
| cmd_cr6 | input | 32 | Assist control word |
| cmd_addr | input | AW | Guest operand byte address |
| cmd_src | input | 8 | Source byte (new key for set key) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_done | output | 1 | Operation completed |
| rsp_decline | output | 1 | Operation handed back to software |
| rsp_cc | output | 2 | Condition code |
| rsp_key | output | 8 | Key result byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Read data |
| key_idx | output | AW-11 | Real key array index |
| key_rdata | input | 8 | Real key at `key_idx` |
| key_we | output | 1 | Real key write strobe |
| key_wdata | output | 8 | Real key write data |

## Verification
The bench builds the walker with the default AW of 24. This gives a 22-bit word port and a 13-bit key index, so every page-frame value of a 16-bit page halfword and both halves of each 4 KiB page map to distinct real keys. With that width the operand address spans all 16 values of address>>20, which puts the segment-length comparison within reach both at equality and on either side. Both segment splits reach their full segment and page ranges inside the bench's table layout. The memory model acknowledges after zero to two wait cycles, and the consumer stalls for zero to two cycles, so both handshakes are exercised under back-pressure.

// File: rtl/skey_pkg.sv
package skey_pkg;
  typedef enum logic [1:0] {
    OP_RESET_REF = 2'd0,
    OP_INSERT    = 2'd1,
    OP_SET       = 2'd2,
    OP_BAD       = 2'd3
  } skey_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_W0, S_SEG, S_SWB, S_SWF, S_PGC,
    S_KRD, S_KWR, S_SWW, S_VP, S_PSW, S_RSP
  } skey_state_e;

  localparam logic [31:0] RST_MASK_ODD  = 32'hFCFF_FFFB;
  localparam logic [31:0] RST_MASK_EVEN = 32'hF3FF_FBFF;
  localparam logic [31:0] SET_MASK_ODD  = 32'hFCFF_FF00;
  localparam logic [31:0] SET_MASK_EVEN = 32'hF3FF_00FF;
endpackage

// File: rtl/skey_addr.sv
module skey_addr #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] op_addr,
  input  logic          big_seg,
  input  logic [AW-3:0] seg_base,
  input  logic [AW-1:0] seg_ent,
  input  logic [AW-1:0] swap_base,
  output logic [AW-3:0] seg_word,
  output logic [AW-3:0] swb_word,
  output logic [AW-3:0] swf_word,
  output logic [AW-3:0] pgc_word,
  output logic          page_odd
);
  localparam int WA = AW - 2;

  logic [AW-1:0] seg_idx;
  logic [6:0]    page_no;
  logic [AW-1:0] sw_byte;
  logic [AW-1:0] pg_byte;
  logic          unused_addr;

  // R3: segment/page split chosen by the control block word 0 bit 0
  always_comb begin
    if (big_seg) begin
      seg_idx = AW'(op_addr[AW-1:19]);
      page_no = op_addr[18:12];
    end else begin
      seg_idx = AW'(op_addr[AW-1:16]);
      page_no = {3'b000, op_addr[15:12]};
    end
  end

  // R5: table entry locations
  assign seg_word = seg_base + seg_idx[WA-1:0];
  assign swb_word = seg_ent[AW-1:2] - WA'(1);
  assign sw_byte  = swap_base + AW'({page_no, 3'b000});
  assign pg_byte  = seg_ent + AW'({page_no, 1'b0});
  assign swf_word = sw_byte[AW-1:2];
  assign pgc_word = pg_byte[AW-1:2];
  assign page_odd = page_no[0];

  assign unused_addr = ^{op_addr[11:0], sw_byte[1:0], pg_byte[1:0]};
endmodule

// File: rtl/skey_keycalc.sv
module skey_keycalc #(
  parameter int AW = 24
) (
  input  skey_pkg::skey_op_e op,
  input  logic              half_odd,
  input  logic              page_odd,
  input  logic [31:0]       page_word,
  input  logic [31:0]       swap_flags,
  input  logic [7:0]        real_key,
  input  logic [7:0]        src,
  input  logic              ext_mode,
  output logic              resident,
  output logic [AW-12:0]    kidx,
  output logic [7:0]        out_key,
  output logic [1:0]        cc,
  output logic [7:0]        new_rk,
  output logic [31:0]       new_swf
);
  import skey_pkg::*;

  logic [15:0] half;
  logic [27:0] real_byte;
  logic [7:0]  vkey;
  logic [7:0]  merged;
  logic        unused_half;

  // R5/R6: even page in the upper halfword, residency, real key index
  assign half      = page_odd ? page_word[15:0] : page_word[31:16];
  assign resident  = (half[3:1] == 3'b000);
  assign real_byte = {half[15:4], half_odd, 11'd0};
  assign kidx      = real_byte[AW-1:11];

  // R7: virtual key with real reference/change merged
  assign vkey   = (half_odd ? swap_flags[7:0] : swap_flags[15:8]) & 8'hFE;
  assign merged = vkey | (resident ? (real_key & 8'h06) : 8'h00);
  assign cc     = merged[2:1];

  always_comb begin
    out_key = merged;
    new_rk  = real_key & 8'hFB;
    new_swf = swap_flags & (half_odd ? RST_MASK_ODD : RST_MASK_EVEN);
    unique case (op)
      OP_INSERT: begin
        out_key = ext_mode ? merged : {merged[7:4], 4'h0};
        new_swf = swap_flags;
        new_rk  = real_key;
      end
      OP_SET: begin
        new_rk  = {src[7:4], real_key[3:0]};
        out_key = {src[7:4], real_key[3:0]};
        if (half_odd)
          new_swf = (swap_flags & SET_MASK_ODD) |
                    {6'd0, real_key[2:1], 16'd0, src};
        else
          new_swf = (swap_flags & SET_MASK_EVEN) |
                    {4'd0, real_key[2:1], 10'd0, src, 8'd0};
      end
      default: ;
    endcase
  end

  assign unused_half = half[0];
endmodule

// File: rtl/skey_walker.sv
module skey_walker #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [31:0]   cmd_cr6,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_src,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_done,
  output logic          rsp_decline,
  output logic [1:0]    rsp_cc,
  output logic [7:0]    rsp_key,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-3:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [AW-12:0] key_idx,
  input  logic [7:0]    key_rdata,
  output logic          key_we,
  output logic [7:0]    key_wdata
);
  import skey_pkg::*;

  localparam int WA  = AW - 2;
  localparam int KIW = AW - 11;

  skey_state_e   state;
  skey_op_e      op_q;
  logic [AW-12:0] addr_q;
  logic [7:0]    src_q;
  logic          decl_q;
  logic [WA-1:0] cbw_q;
  logic          big_q;
  logic [WA-1:0] sbase_q;
  logic [AW-1:0] sent_q;
  logic [AW-1:0] swb_q;
  logic [31:0]   swf_q;
  logic [31:0]   pgc_q;
  logic [7:0]    rk_q;
  logic [WA-1:0] vptr_q;
  logic          ext_q;

  logic [WA-1:0] seg_word, swb_word, swf_word, pgc_word;
  logic          page_odd;
  logic          resident;
  logic [KIW-1:0] kidx;
  logic [7:0]    out_key, new_rk;
  logic [1:0]    cc;
  logic [31:0]   new_swf;
  logic [7:0]    seg_lim;
  logic          early_decl;
  logic          unused_cmd;

  assign seg_lim    = 8'({addr_q, 11'd0} >> 20);
  // R1: early decline conditions
  assign early_decl = (cmd_cr6[31:29] != 3'b100) || (cmd_op == 2'd3) ||
                      ((cmd_op == 2'd2) && (cmd_src[3:0] != 4'h0));
  assign unused_cmd = ^{cmd_cr6[28:AW], cmd_cr6[2:0], cmd_addr[10:0]};

  skey_addr #(.AW(AW)) u_addr (
    .op_addr  ({addr_q, 11'd0}),
    .big_seg  (big_q),
    .seg_base (sbase_q),
    .seg_ent  (sent_q),
    .swap_base(swb_q),
    .seg_word (seg_word),
    .swb_word (swb_word),
    .swf_word (swf_word),
    .pgc_word (pgc_word),
    .page_odd (page_odd)
  );

  skey_keycalc #(.AW(AW)) u_key (
    .op        (op_q),
    .half_odd  (addr_q[0]),
    .page_odd  (page_odd),
    .page_word (pgc_q),
    .swap_flags(swf_q),
    .real_key  (rk_q),
    .src       (src_q),
    .ext_mode  (ext_q),
    .resident  (resident),
    .kidx      (kidx),
    .out_key   (out_key),
    .cc        (cc),
    .new_rk    (new_rk),
    .new_swf   (new_swf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_RESET_REF;
      addr_q  <= '0;
      src_q   <= '0;
      decl_q  <= 1'b0;
      cbw_q   <= '0;
      big_q   <= 1'b0;
      sbase_q <= '0;
      sent_q  <= '0;
      swb_q   <= '0;
      swf_q   <= '0;
      pgc_q   <= '0;
      rk_q    <= '0;
      vptr_q  <= '0;
      ext_q   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          op_q   <= skey_op_e'(cmd_op);
          addr_q <= cmd_addr[AW-1:11];
          src_q  <= cmd_src;
          rk_q   <= '0;
          ext_q  <= 1'b0;
          cbw_q  <= {cmd_cr6[AW-1:3], 1'b0};
          decl_q <= early_decl;
          state  <= early_decl ? S_RSP : S_W0;
        end
        S_W0: if (mem_ack) begin
          big_q   <= mem_rdata[0];
          sbase_q <= mem_rdata[AW-1:2];
          if (mem_rdata[1]) begin      // R2
            decl_q <= 1'b1;
            state  <= S_RSP;
          end else begin
            state <= S_SEG;
          end
        end
        S_SEG: if (mem_ack) begin
          sent_q <= mem_rdata[AW-1:0];
          if (mem_rdata[31:24] <= seg_lim) begin   // R4
            decl_q <= 1'b1;
            state  <= S_RSP;
          end else begin
            state <= S_SWB;
          end
        end
        S_SWB: if (mem_ack) begin
          swb_q <= mem_rdata[AW-1:0];
          state <= S_SWF;
        end
        S_SWF: if (mem_ack) begin
          swf_q <= mem_rdata;
          state <= S_PGC;
        end
        S_PGC: if (mem_ack) begin
          pgc_q <= mem_rdata;
          state <= S_KRD;
        end
        S_KRD: begin
          if (resident) rk_q <= key_rdata;
          if (op_q == OP_SET && !resident) begin   // R9
            decl_q <= 1'b1;
            state  <= S_RSP;
          end else if (op_q == OP_INSERT) begin
            state <= S_VP;
          end else if (resident) begin
            state <= S_KWR;
          end else begin
            state <= S_SWW;
          end
        end
        S_KWR: state <= S_SWW;
        S_SWW: if (mem_ack) state <= S_RSP;
        S_VP: if (mem_ack) begin
          vptr_q <= mem_rdata[AW-1:2];
          state  <= S_PSW;
        end
        S_PSW: if (mem_ack) begin
          ext_q <= mem_rdata[19];
          state <= S_RSP;
        end
        S_RSP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr = cbw_q;
    unique case (state)
      S_SEG:   mem_addr = seg_word;
      S_SWB:   mem_addr = swb_word;
      S_SWF:   mem_addr = swf_word;
      S_PGC:   mem_addr = pgc_word;
      S_SWW:   mem_addr = swf_word;
      S_VP:    mem_addr = cbw_q + WA'(2);
      S_PSW:   mem_addr = vptr_q;
      default: mem_addr = cbw_q;
    endcase
  end

  assign mem_req   = (state == S_W0)  || (state == S_SEG) || (state == S_SWB) ||
                     (state == S_SWF) || (state == S_PGC) || (state == S_VP)  ||
                     (state == S_PSW) || (state == S_SWW);
  assign mem_we    = (state == S_SWW);
  assign mem_wdata = new_swf;
  assign key_idx   = kidx;
  assign key_we    = (state == S_KWR);
  assign key_wdata = new_rk;

  assign cmd_ready   = (state == S_IDLE);
  assign rsp_valid   = (state == S_RSP);
  assign rsp_done    = rsp_valid && !decl_q;
  assign rsp_decline = rsp_valid && decl_q;
  assign rsp_cc      = (rsp_done && op_q == OP_RESET_REF) ? cc : 2'b00;
  assign rsp_key     = rsp_done ? out_key : 8'h00;

  // Assertions
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_done ^ rsp_decline));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid &&
      $stable({rsp_done, rsp_decline, rsp_cc, rsp_key})));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_cr6[31:29] != 3'b100) |=>
      (rsp_valid && rsp_decline));

  assert_basic_nibble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && op_q == OP_INSERT && !ext_q) |-> (rsp_key[3:0] == 4'h0));

  assert_no_write_after_decl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we || mem_we) |-> !decl_q);
endmodule

// File: tb/skey_walker_tb.sv
module skey_walker_tb;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_cr6 = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]  cmd_src = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_done, rsp_decline;
  logic [1:0]  rsp_cc;
  logic [7:0]  rsp_key;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-3:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [AW-12:0] key_idx;
  logic [7:0]  key_rdata, key_wdata;
  logic        key_we;

  logic [31:0] mem [int unsigned];
  logic [7:0]  keys [0:8191];
  int          lat = 0;
  int          checks = 0, fails = 0;

  skey_walker #(.AW(AW)) u_dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_cr6, .cmd_addr, .cmd_src,
    .rsp_valid, .rsp_ready, .rsp_done, .rsp_decline, .rsp_cc, .rsp_key,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .key_idx, .key_rdata, .key_we, .key_wdata
  );

  function automatic logic [31:0] mrd(input int unsigned a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[int'({10'd0, mem_addr})] = mem_wdata;
        else mem_rdata <= mrd(int'({10'd0, mem_addr}));
        lat <= int'($urandom % 3);
      end else lat <= lat - 1;
    end
  end

  assign key_rdata = keys[key_idx];
  always @(posedge clk) if (key_we) keys[key_idx] <= key_wdata;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One scenario: build tables, run, compare against expectations from the requirements
  task automatic scen(input logic [1:0] op, input logic [31:0] cr6, input logic big,
                      input logic [23:0] addr, input logic [7:0] src, input logic [7:0] len,
                      input logic w0b1, input logic [15:0] half, input logic [31:0] swf,
                      input logic [31:0] vpsw, input logic [7:0] rk);
    int unsigned seg, pg, pt, swb, swfw, pgw;
    logic odd, res, decl;
    logic [7:0] vk, mk, ek, erk;
    logic [1:0] ecc;
    logic [31:0] eswf;
    logic [12:0] idx;
    string tag;
    logic d, dn;
    logic [1:0] c;
    logic [7:0] k;
    mem.delete();
    seg = big ? int'(addr[23:19]) : int'(addr[23:16]);      // R3
    pg  = big ? int'(addr[18:12]) : int'(addr[15:12]);
    pt  = 32'h10000 + seg * 32'h400;
    swb = 32'h80000 + seg * 32'h1000;
    mem[32'h400] = 32'h2000 | {30'd0, w0b1, big};
    mem[32'h402] = 32'h3000;
    mem[32'h3000 >> 2] = vpsw;
    mem[(32'h2000 >> 2) + seg] = {len, pt[23:0]};
    mem[(pt >> 2) - 1] = swb;                                // R5
    swfw = (swb + 8 * pg) >> 2;
    pgw  = (pt + 2 * pg) >> 2;
    mem[swfw] = swf;
    mem[pgw] = pg[0] ? {16'hA5C3, half} : {half, 16'h3C5A};
    odd = addr[11];
    idx = {half[15:4], odd};                                 // R6
    keys[idx] = rk;
    res = (half[3:1] == 3'b000);
    vk  = (odd ? swf[7:0] : swf[15:8]) & 8'hFE;              // R7
    mk  = vk | (res ? (rk & 8'h06) : 8'h00);
    decl = 1'b0; tag = "R8";
    if (op == 2'd1) tag = "R10";
    if (op == 2'd2) tag = "R9";
    ek = 8'h00; ecc = 2'b00; erk = rk; eswf = swf;
    if (cr6[31:29] != 3'b100 || op == 2'd3 || (op == 2'd2 && src[3:0] != 0)) begin
      decl = 1'b1; tag = "R1";
    end else if (w0b1) begin decl = 1'b1; tag = "R2"; end
    else if (len <= {4'd0, addr[23:20]}) begin decl = 1'b1; tag = "R4"; end
    else if (op == 2'd2 && !res) begin decl = 1'b1; tag = "R9"; end
    if (!decl) begin
      case (op)
        2'd0: begin
          ek = mk; ecc = mk[2:1];
          if (res) erk = rk & 8'hFB;
          eswf = swf & (odd ? 32'hFCFF_FFFB : 32'hF3FF_FBFF);
        end
        2'd1: ek = vpsw[19] ? mk : {mk[7:4], 4'h0};
        default: begin
          erk = {src[7:4], rk[3:0]}; ek = erk;
          eswf = odd ? ((swf & 32'hFCFF_FF00) | {6'd0, rk[2:1], 16'd0, src})
                     : ((swf & 32'hF3FF_00FF) | {4'd0, rk[2:1], 10'd0, src, 8'd0});
        end
      endcase
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_cr6 = cr6; cmd_addr = addr; cmd_src = src;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat ($urandom % 3) @(negedge clk);
    d = rsp_decline; dn = rsp_done; c = rsp_cc; k = rsp_key;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(tag, "outcome", {30'd0, dn, d}, {30'd0, !decl, decl});   // R11 single outcome
    chk(tag, "cc", {30'd0, c}, {30'd0, ecc});
    chk(tag, "key", {24'd0, k}, {24'd0, ek});                     // R7 merge
    chk(tag, "swap flags", mrd(swfw), eswf);                      // R5 location
    chk(tag, "real key", {24'd0, keys[idx]}, {24'd0, erk});       // R6 index
  endtask

  task automatic rnd_scen();
    logic [1:0] op;
    logic [31:0] cr6;
    logic [23:0] addr;
    logic [7:0] src, len;
    logic [15:0] half;
    op = 2'($urandom % 3);
    if ($urandom % 16 == 0) op = 2'd3;
    cr6 = ($urandom % 10 == 0) ? ($urandom & 32'h7FFF_FFFF) : 32'h8000_1000;
    addr = 24'($urandom);
    src = 8'($urandom);
    if (op == 2'd2 && $urandom % 4 != 0) src[3:0] = 4'h0;
    len = ($urandom % 5 != 0) ? 8'({4'd0, addr[23:20]} + 8'd1 + 8'($urandom % 8))
                              : 8'($urandom % (32'(addr[23:20]) + 1));
    half = 16'($urandom);
    if ($urandom % 4 != 0) half[3:1] = 3'b000;
    else if (half[3:1] == 3'b000) half[2] = 1'b1;
    scen(op, cr6, 1'($urandom), addr, src, len, ($urandom % 20 == 0),
         half, $urandom, $urandom, 8'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8192; i++) keys[i] = 8'h00;
    repeat (3) @(negedge clk);
    // reset state
    chk("R11", "reset cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R11", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11", "reset mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    // Directed corners
    scen(2'd0, 32'h4000_1000, 0, 24'h123800, 8'h00, 8'h20, 0, 16'h1230, 32'h1234_5678, 0, 8'h36); // R1 disabled
    scen(2'd3, 32'h8000_1000, 0, 24'h123800, 8'h00, 8'h20, 0, 16'h1230, 32'h1234_5678, 0, 8'h36); // R1 bad opcode
    scen(2'd2, 32'h8000_1000, 0, 24'h123800, 8'h51, 8'h20, 0, 16'h1230, 32'h1234_5678, 0, 8'h36); // R1 set nibble
    scen(2'd0, 32'h8000_1000, 1, 24'h123800, 8'h00, 8'h20, 1, 16'h1230, 32'h1234_5678, 0, 8'h36); // R2
    scen(2'd0, 32'h8000_1000, 0, 24'h523800, 8'h00, 8'h05, 0, 16'h1230, 32'h1234_5678, 0, 8'h36); // R4 equal
    scen(2'd0, 32'h8000_1000, 0, 24'h523800, 8'h00, 8'h06, 0, 16'h1230, 32'h1234_5678, 0, 8'h36); // R4 just above
    scen(2'd0, 32'h8000_1000, 0, 24'h0F2800, 8'h00, 8'h01, 0, 16'hABC1, 32'hFFFF_FFFF, 0, 8'hF6); // R8 odd half
    scen(2'd0, 32'h8000_1000, 1, 24'h0F3000, 8'h00, 8'h01, 0, 16'hABC0, 32'hFFFF_FFFF, 0, 8'hF6); // R8 even half, R3 big
    scen(2'd0, 32'h8000_1000, 0, 24'h0F3000, 8'h00, 8'h01, 0, 16'hABC4, 32'hFFFF_FFFF, 0, 8'hF6); // R6 non-resident
    scen(2'd2, 32'h8000_1000, 0, 24'h0F2800, 8'h90, 8'h01, 0, 16'hABC2, 32'h0, 0, 8'h06);         // R9 non-resident
    scen(2'd2, 32'h8000_1000, 0, 24'h0F2800, 8'h90, 8'h01, 0, 16'hABC0, 32'h0, 0, 8'h06);         // R9 odd
    scen(2'd2, 32'h8000_1000, 1, 24'h0F3000, 8'hE0, 8'h01, 0, 16'h5550, 32'hFFFF_FFFF, 0, 8'h04); // R9 even
    scen(2'd1, 32'h8000_1000, 0, 24'h0F2800, 8'h00, 8'h01, 0, 16'hABC0, 32'h0000_00FE, 32'h0000_0000, 8'h06); // R10 basic
    scen(2'd1, 32'h8000_1000, 0, 24'h0F2800, 8'h00, 8'h01, 0, 16'hABC0, 32'h0000_00FE, 32'h0008_0000, 8'h06); // R10 ext
    for (int i = 0; i < 400; i++) rnd_scen();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule